// File: doc/BRIEF.md
# Sequential-Parallel Work Unit Sequencer

This block runs a fixed four-unit schedule each time it is started. Unit A runs first. Units B and C then run together in a parallel section. Unit D runs last, after both B and C have finished. Each unit is driven through its own go/done pair. The whole schedule is started and reported through a top-level start/finish handshake. A top-level state machine walks the schedule. A parallel-section controller keeps one completion latch per child and reports the section finished once every latch is set.

Units A and B may write the same storage element, so they share a single done line. Every child done is therefore only acted on in the controller state where that child actually runs. As a result, the done pulse that A leaves on the shared line cannot be mistaken for B finishing. It can neither hold back B's go nor mark B complete. The parallel section is entered early: it begins in the same cycle that A reports done.

Top module: `seqpar_sched`

## Requirements
- R1: After reset, and while `start` is low in the first state, every unit go output and `finish` are low.
- R2: With `start` high in the first state, `a_go` is asserted until `a_done` is seen. A is started exactly once per run. At most one of A, D and the parallel section drives a go in any cycle.
- R3: In the cycle that `a_done` is high in the first state with `start` high, both `b_go` and `c_go` are asserted, which is the early entry to the parallel section. The machine is in the parallel state on the next cycle.
- R4: A done seen on `b_done` while the machine is not in the parallel state neither suppresses `b_go` nor sets B's completion latch. B is started exactly once per run, even when `b_done` is the same line as `a_done`.
- R5: Inside the parallel section, a child's go is asserted while neither its latch nor its state-qualified done is set. A qualified done sets that child's latch on the next cycle, and the child's go then stays low.
- R6: The parallel section finishes only after every child has reported done, whatever the children's relative latencies. D starts on the cycle after the section finishes.
- R7: `d_go` is asserted until `d_done`. On the next cycle `finish` is high for exactly one cycle.
- R8: All completion latches are clear whenever the machine is outside the parallel state. Back-to-back runs with `start` held high each start every unit exactly once. With `start` low the block stays idle.
- R9: After a run where A writes 0 and B writes 1 to the shared register, and D then stores that register, the stored value is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Top-level go; held high to run the schedule |
| finish | output | 1 | One-cycle pulse when the schedule completes |
| a_go | output | 1 | Go for unit A |
| a_done | input | 1 | Done from unit A |
| b_go | output | 1 | Go for unit B (parallel child 0) |
| b_done | input | 1 | Done from unit B; may be the same line as `a_done` |
| c_go | output | 1 | Go for unit C (parallel child 1) |
| c_done | input | 1 | Done from unit C |
| d_go | output | 1 | Go for unit D |
| d_done | input | 1 | Done from unit D |

## Verification
Two events fall in the same cycle. A's completion lands on the shared done line in the very cycle that the parallel section is entered and B is first given its go. The bench provokes this by tying `b_done` to `a_done` through a model register that raises done one cycle after either A or B writes it. It judges the outcome in three ways: it checks that `b_go` and `c_go` are high exactly when `a_done` is, it counts one start per unit per run, and it checks that D stores the value 1 written by B. Runs vary C's latency and alternate between held and released `start`.

// File: rtl/sched_pkg.sv
package sched_pkg;

  typedef enum logic [1:0] {
    ST_A   = 2'd0,
    ST_PAR = 2'd1,
    ST_D   = 2'd2,
    ST_FIN = 2'd3
  } seq_state_e;

  localparam int unsigned PAR_KIDS = 2;

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/par_ctrl.sv
module par_ctrl #(
  parameter int unsigned N_KIDS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_go,
  input  logic              ctx_run,
  input  logic [N_KIDS-1:0] kid_done,
  output logic [N_KIDS-1:0] kid_go,
  output logic              sec_done
);

  logic [N_KIDS-1:0] lat_q;
  logic [N_KIDS-1:0] qual_done;
  logic              clr;

  // a child's done counts only while the enclosing state is the parallel one
  assign qual_done = kid_done & {N_KIDS{ctx_run}};
  assign sec_done  = &lat_q;
  assign clr       = sec_done & ctx_run;

  for (genvar i = 0; i < N_KIDS; i++) begin : g_kid
    logic lat_en;
    logic lat_d;

    assign lat_en    = clr | qual_done[i];
    assign lat_d     = ~clr;
    assign kid_go[i] = sec_go & ~(lat_q[i] | qual_done[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lat_q[i] <= 1'b0;
      end else if (lat_en) begin
        lat_q[i] <= lat_d;
      end
    end

    // R5: a qualified done marks the child complete on the next cycle
    p_latch_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctx_run && kid_done[i] && !lat_q[i]) |=> lat_q[i]);

    // R5: once complete, the child is not started again
    p_no_rego_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctx_run && kid_done[i]) |=> !kid_go[i]);
  end

  // R8: leaving the section clears every latch
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_done && ctx_run) |=> (lat_q == '0));

  // R4: outside the parallel state nothing is recorded as complete
  p_no_stale_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctx_run |-> (lat_q == '0));

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import sched_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       top_go,
  input  logic       a_done,
  input  logic       par_done,
  input  logic       d_done,
  output seq_state_e state,
  output logic       a_go,
  output logic       par_go,
  output logic       d_go,
  output logic       top_done
);

  seq_state_e state_q, state_d;
  logic       st_en;

  always_comb begin
    state_d  = state_q;
    a_go     = 1'b0;
    par_go   = 1'b0;
    d_go     = 1'b0;
    top_done = 1'b0;
    unique case (state_q)
      ST_A: begin
        if (top_go) begin
          a_go = ~a_done;
          if (a_done) begin
            par_go  = 1'b1;   // early entry into the parallel section
            state_d = ST_PAR;
          end
        end
      end
      ST_PAR: begin
        par_go = ~par_done;
        if (par_done) state_d = ST_D;
      end
      ST_D: begin
        d_go = ~d_done;
        if (d_done) state_d = ST_FIN;
      end
      ST_FIN: begin
        top_done = 1'b1;
        state_d  = ST_A;
      end
      default: state_d = ST_A;
    endcase
  end

  assign st_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_A;
    end else if (st_en) begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

  // R3: A finishing moves straight into the parallel state
  p_early_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_A && top_go && a_done) |=> (state_q == ST_PAR));

  // R7: D finishing yields a top-level done on the next cycle
  p_d_to_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_D && d_done) |=> top_done);

  // R7: top-level done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    top_done |=> !top_done);

  // R1: with go low in the first state nothing is driven
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_A && !top_go) |-> !(a_go || par_go || d_go || top_done));

endmodule

// File: rtl/seqpar_sched.sv
module seqpar_sched
  import sched_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic finish,
  output logic a_go,
  input  logic a_done,
  output logic b_go,
  input  logic b_done,
  output logic c_go,
  input  logic c_done,
  output logic d_go,
  input  logic d_done
);

  logic                rst_n_s;
  seq_state_e          state;
  logic                par_go;
  logic                par_done;
  logic                ctx_run;
  logic [PAR_KIDS-1:0] kid_go;
  logic [PAR_KIDS-1:0] kid_done;

  rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_s)
  );

  seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .top_go   (start),
    .a_done   (a_done),
    .par_done (par_done),
    .d_done   (d_done),
    .state    (state),
    .a_go     (a_go),
    .par_go   (par_go),
    .d_go     (d_go),
    .top_done (finish)
  );

  assign ctx_run  = (state == ST_PAR);
  assign kid_done = {c_done, b_done};

  par_ctrl #(.N_KIDS(PAR_KIDS)) u_par (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .sec_go   (par_go),
    .ctx_run  (ctx_run),
    .kid_done (kid_done),
    .kid_go   (kid_go),
    .sec_done (par_done)
  );

  assign b_go = kid_go[0];
  assign c_go = kid_go[1];

  // R2: A, the parallel section and D never drive go together
  p_one_phase_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0({a_go, (b_go | c_go), d_go}));

  // R6: D starts only once the section has completed
  p_d_after_par_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ctx_run && par_done) |=> d_go);

endmodule

// File: tb/tb_seqpar_sched.sv
`timescale 1ns/1ps
module tb_seqpar_sched;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic finish, a_go, b_go, c_go, d_go;
  logic shared_done, c_done, d_done;

  always #2.5 clk = ~clk;

  seqpar_sched dut (
    .clk(clk), .rst_n(rst_n), .start(start), .finish(finish),
    .a_go(a_go), .a_done(shared_done),
    .b_go(b_go), .b_done(shared_done),
    .c_go(c_go), .c_done(c_done),
    .d_go(d_go), .d_done(d_done)
  );

  // unit models: A writes 0, B writes 1 to one shared register whose done
  // rises one cycle after any write; D stores that register
  logic       shared_q;
  logic       mem_q;
  logic [3:0] c_cnt;
  int         c_lat = 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shared_q    <= 1'b1;
      shared_done <= 1'b0;
      mem_q       <= 1'b0;
      d_done      <= 1'b0;
      c_cnt       <= '0;
    end else begin
      if (a_go) shared_q <= 1'b0;
      else if (b_go) shared_q <= 1'b1;
      shared_done <= a_go | b_go;
      if (d_go) mem_q <= shared_q;
      d_done <= d_go;
      if (c_go && c_cnt == 0) c_cnt <= 4'(c_lat);
      else if (c_cnt != 0) c_cnt <= c_cnt - 4'd1;
    end
  end
  assign c_done = (c_cnt == 4'd1);

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct { int mem; int starts; } exp_t;
  exp_t sb[$];

  int n_a, n_b, n_c, n_d;
  bit prev_finish = 1'b0;
  bit mon_on = 1'b0;

  // monitor: counts starts, checks the early entry, pops on finish
  always @(negedge clk) begin
    if (mon_on) begin
      if (a_go) n_a++;
      if (b_go) n_b++;
      if (c_go && c_cnt == 0) n_c++;
      if (d_go) n_d++;
      if (shared_done && start && !b_go && !c_go && n_b == 0) begin
        chk(1'b0, "R3 early entry b_go/c_go", {30'd0, b_go, c_go}, 3);
      end
      if (prev_finish) chk(!finish, "R7 finish pulse width", finish, 0);
      if (finish) begin
        exp_t e;
        if (sb.size() == 0) begin
          chk(1'b0, "R7 unexpected finish", 1, 0);
        end else begin
          e = sb.pop_front();
          chk(n_a == e.starts, "R2 A starts per run", n_a, e.starts);
          chk(n_b == e.starts, "R4 B starts per run", n_b, e.starts);
          chk(n_c == e.starts, "R6 C starts per run", n_c, e.starts);
          chk(n_d == e.starts, "R7 D starts per run", n_d, e.starts);
          chk(int'(mem_q) == e.mem, "R9 stored value", mem_q, e.mem);
        end
        n_a = 0; n_b = 0; n_c = 0; n_d = 0;
      end
      prev_finish = finish;
    end
  end

  // driver: queue the expected result, then run the schedule
  task automatic run_once(input int lat, input bit drop);
    exp_t e;
    e.mem = 1; e.starts = 1;
    sb.push_back(e);
    c_lat = lat;
    @(negedge clk);
    start = 1'b1;
    do @(negedge clk); while (!finish);
    if (drop) start = 1'b0;
  endtask

  task automatic idle_check(input int cycles);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      chk(!(a_go || b_go || c_go || d_go || finish), "R8 idle with start low",
          {27'd0, a_go, b_go, c_go, d_go, finish}, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!(a_go || b_go || c_go || d_go || finish), "R1 outputs during reset",
        {27'd0, a_go, b_go, c_go, d_go, finish}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!(a_go || b_go || c_go || d_go || finish), "R1 outputs after reset",
        {27'd0, a_go, b_go, c_go, d_go, finish}, 0);
    mon_on = 1'b1;
    run_once(1, 1'b1);            // equal child latencies
    idle_check(4);
    run_once(4, 1'b1);            // C slower than B
    idle_check(3);
    run_once(2, 1'b0);            // start held: back-to-back runs
    run_once(1, 1'b1);
    idle_check(3);
    chk(sb.size() == 0, "R8 all runs completed", sb.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule